// File: doc/BRIEF.md
# DRAM Data Pin Output Controller

This block decides, clock by clock, what a DRAM's data pins do. The pins can drive data from the memory array, drive a value held in an output register, or float. The four active-low strobes (row strobe, column strobe, write enable, output enable) are treated as asynchronous inputs. They are synchronised to a fast system clock, edge-detected, and used to classify each memory cycle. The data word from the array arrives on `rd_data`. The block produces a tristate enable, the output data register and a one-clock write strobe to the array.

The output state depends on how a cycle was entered:

- **Normal row cycle.** The column strobe falls after the row strobe.
  - A read drives array data.
  - A late write or read-modify-write releases the drivers while write enable is low.
  - An early write keeps the pins floating for the whole column access.
- **Column-before-row cycle.** The column strobe is already low when the row strobe falls. This is a refresh, and the pins keep whatever state the previous cycle left them in.
- **Row strobe rising.** While the drivers are on, a rising row strobe freezes the output data. The frozen value stays on the pins until the column strobe rises.

Top module: `dram_dq_ctrl`

## Requirements
- R1: A change on any strobe reaches the outputs on the third rising clock edge after it (SYNC_STAGES + 1 with the default of 2). Before that edge the outputs keep their previous values.
- R2: In a normal row cycle, a column access begun with write enable high is a read. With output enable low, `dq_oe` is 1 and `dq_out` follows `rd_data`.
- R3: While the column strobe is high, `dq_oe` is 0. A cycle with only the row strobe low never turns the drivers on.
- R4: Output enable high forces `dq_oe` to 0 and leaves `dq_out` unchanged. Taking output enable low again restores the drivers with the same data.
- R5: In a row cycle, write enable falling while the column strobe is low (late write or read-modify-write) gives exactly one `arr_we` pulse one clock wide. The drivers are off while write enable is low, and `dq_out` holds its value.
- R6: Write enable already low when the column strobe falls (early write) gives one `arr_we` pulse. `dq_oe` stays 0 until the column strobe rises, even if write enable returns high.
- R7: When the row strobe rises while the column strobe is low and `dq_oe` is 1, `dq_out` is frozen. Further `rd_data` changes are ignored, and the value stays driven, still gated by output enable, until the column strobe rises.
- R8: The column strobe falling while the row strobe is high does not change `dq_oe` or `dq_out` and produces no `arr_we` pulse.
- R9: A row strobe falling while the column strobe is already low starts a refresh cycle. `dq_oe` and `dq_out` keep their state from the previous cycle (output enable still gates the drivers), and write enable low gives no `arr_we` pulse.
- R10: Reset (rst_n low, asynchronous) clears `dq_oe`, `dq_out` and `arr_we` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DATA_W | Word read from the array for the selected cell |
| dq_oe | output | 1 | Tristate driver enable for the data pins |
| dq_out | output | DATA_W | Output data register driven onto the pins |
| arr_we | output | 1 | One-clock write strobe to the array |

## Verification
Each strobe passes through two synchroniser flops and then one output register, so `dq_oe`, `dq_out` and `arr_we` respond on the third rising edge after the stimulus.

The vector walk applies each input set just after a rising edge and waits five edges. It then samples at the falling edge, well after every result has settled. The write strobe is counted at falling edges across the whole step, so a pulse one clock wide is neither missed nor counted twice.

A directed test checks the exact edge: the drivers must still be off after the second edge and on after the third.

// File: rtl/dram_dq_pkg.sv
package dram_dq_pkg;

   // Kind of memory cycle currently open
   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,   // row strobe high
      CYC_ROW  = 2'd1,   // normal row access
      CYC_RFSH = 2'd2    // column-before-row refresh
   } cyc_e;

   localparam int unsigned N_STROBES = 4;

   // Bit positions of the strobes inside the synchroniser vector
   localparam int unsigned IDX_RAS = 3;
   localparam int unsigned IDX_CAS = 2;
   localparam int unsigned IDX_WE  = 1;
   localparam int unsigned IDX_OE  = 0;

endpackage

// File: rtl/dram_dq_sync.sv
module dram_dq_sync #(
   parameter int unsigned N_SIG  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] raw_n,
   output logic [N_SIG-1:0] lvl,
   output logic [N_SIG-1:0] on,
   output logic [N_SIG-1:0] off
);

   logic [N_SIG-1:0] synced_n;
   logic [N_SIG-1:0] prev_lvl;

   for (genvar g = 0; g < N_SIG; g++) begin : g_sig
      if (STAGES == 1) begin : g_single
         logic flop;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flop <= 1'b1;
            else        flop <= raw_n[g];
         end
         assign synced_n[g] = flop;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw_n[g]};
         end
         assign synced_n[g] = chain[STAGES-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= '0;
      else        prev_lvl <= lvl;
   end

   assign lvl = ~synced_n;
   assign on  = lvl & ~prev_lvl;
   assign off = ~lvl & prev_lvl;

endmodule

// File: rtl/dram_dq_cycle.sv
module dram_dq_cycle
   import dram_dq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ras_on,
   input  logic ras_off,
   input  logic cas_lvl,
   input  logic cas_on,
   input  logic cas_off,
   input  logic we_lvl,
   input  logic drv_on,
   output cyc_e state,
   output logic row_act,
   output logic early,
   output logic held
);

   logic enter_rfsh;

   // Column strobe already low (not just falling) when the row strobe falls
   assign enter_rfsh = ras_on & cas_lvl & ~cas_on;

   // Row access in force at this edge, including the edge that opens it
   assign row_act = (state == CYC_ROW) | (ras_on & ~enter_rfsh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CYC_IDLE;
      end else if (ras_on) begin
         state <= enter_rfsh ? CYC_RFSH : CYC_ROW;
      end else if (ras_off) begin
         state <= CYC_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         early <= 1'b0;
      end else if (cas_off) begin
         early <= 1'b0;
      end else if (cas_on && row_act) begin
         early <= we_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
      end else if (cas_off) begin
         held <= 1'b0;
      end else if (ras_off && state != CYC_IDLE) begin
         held <= cas_lvl & (drv_on | held);
      end
   end

endmodule

// File: rtl/dram_dq_drive.sv
module dram_dq_drive #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_act,
   input  logic              early,
   input  logic              held,
   input  logic              cas_lvl,
   input  logic              cas_on,
   input  logic              we_lvl,
   input  logic              we_on,
   input  logic              oe_lvl,
   input  logic [DATA_W-1:0] rd_data,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   output logic              arr_we
);

   logic read_path;
   logic oe_nx;
   logic wr_nx;

   assign read_path = row_act & cas_lvl & ~we_lvl & (cas_on | ~early);
   assign oe_nx     = row_act ? (read_path & oe_lvl) : (held & cas_lvl & oe_lvl);
   assign wr_nx     = row_act & ((cas_on & we_lvl) |
                                 (cas_lvl & ~cas_on & we_on & ~early));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_oe  <= 1'b0;
         arr_we <= 1'b0;
      end else begin
         dq_oe  <= oe_nx;
         arr_we <= wr_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dq_out <= '0;
      else if (read_path) dq_out <= rd_data;
   end

endmodule

// File: rtl/dram_dq_ctrl.sv
module dram_dq_ctrl
   import dram_dq_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] rd_data,
   output logic              dq_oe,
   output logic [DATA_W-1:0] dq_out,
   output logic              arr_we
);

   if (DATA_W < 1) begin : g_bad_width
      $error("dram_dq_ctrl: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("dram_dq_ctrl: SYNC_STAGES must be at least 1");
   end

   logic [N_STROBES-1:0] raw_n, lvl, on, off;
   cyc_e state;
   logic row_act, early, held;
   logic unused_edges;

   assign raw_n[IDX_RAS] = ras_n;
   assign raw_n[IDX_CAS] = cas_n;
   assign raw_n[IDX_WE]  = we_n;
   assign raw_n[IDX_OE]  = oe_n;

   assign unused_edges = ^{off[IDX_WE], off[IDX_OE], on[IDX_OE], lvl[IDX_RAS], state};

   dram_dq_sync #(.N_SIG(N_STROBES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_n (raw_n),
      .lvl   (lvl),
      .on    (on),
      .off   (off)
   );

   dram_dq_cycle u_cycle (
      .clk     (clk),
      .rst_n   (rst_n),
      .ras_on  (on[IDX_RAS]),
      .ras_off (off[IDX_RAS]),
      .cas_lvl (lvl[IDX_CAS]),
      .cas_on  (on[IDX_CAS]),
      .cas_off (off[IDX_CAS]),
      .we_lvl  (lvl[IDX_WE]),
      .drv_on  (dq_oe),
      .state   (state),
      .row_act (row_act),
      .early   (early),
      .held    (held)
   );

   dram_dq_drive #(.DATA_W(DATA_W)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .row_act (row_act),
      .early   (early),
      .held    (held),
      .cas_lvl (lvl[IDX_CAS]),
      .cas_on  (on[IDX_CAS]),
      .we_lvl  (lvl[IDX_WE]),
      .we_on   (on[IDX_WE]),
      .oe_lvl  (lvl[IDX_OE]),
      .rd_data (rd_data),
      .dq_oe   (dq_oe),
      .dq_out  (dq_out),
      .arr_we  (arr_we)
   );

endmodule

// File: rtl/dram_dq_ctrl_chk.sv
module dram_dq_ctrl_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cas_lvl,
   input logic              we_lvl,
   input logic              oe_lvl,
   input logic              row_act,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out,
   input logic              arr_we
);

   a_r3_cas_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_lvl |=> !dq_oe);

   a_r4_oe_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_lvl |=> !dq_oe);

   a_r5_we_low_floats: assert property (@(posedge clk) disable iff (!rst_n)
      (row_act && cas_lvl && we_lvl) |=> !dq_oe);

   a_r5_strobe_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |=> !arr_we);

   a_r7_latch_held_off_row: assert property (@(posedge clk) disable iff (!rst_n)
      !row_act |=> $stable(dq_out));

   a_r9_no_strobe_off_row: assert property (@(posedge clk) disable iff (!rst_n)
      !row_act |=> !arr_we);

endmodule

bind dram_dq_ctrl dram_dq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cas_lvl (lvl[dram_dq_pkg::IDX_CAS]),
   .we_lvl  (lvl[dram_dq_pkg::IDX_WE]),
   .oe_lvl  (lvl[dram_dq_pkg::IDX_OE]),
   .row_act (row_act),
   .dq_oe   (dq_oe),
   .dq_out  (dq_out),
   .arr_we  (arr_we)
);

// File: tb/dram_dq_ctrl_bench.sv
module dram_dq_ctrl_bench;

   localparam int DW = 8;
   localparam int NV = 28;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [DW-1:0] rd_data = '0;
   logic dq_oe, arr_we;
   logic [DW-1:0] dq_out;

   int errors = 0;
   int checks = 0;
   int wcount = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dram_dq_ctrl #(.DATA_W(DW), .SYNC_STAGES(2)) u_dram_dq_ctrl (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .rd_data(rd_data), .dq_oe(dq_oe), .dq_out(dq_out), .arr_we(arr_we)
   );

   always @(negedge clk) if (arr_we) wcount++;

   // {ras_n,cas_n,we_n,oe_n, rd_data, exp_oe, exp_out, exp_pulses}
   localparam logic [21:0] VEC [NV] = '{
      {4'b0110, 8'hA1, 1'b0, 8'h00, 1'b0},  // R3 row only
      {4'b0010, 8'hA1, 1'b1, 8'hA1, 1'b0},  // R2 read
      {4'b0011, 8'hA1, 1'b0, 8'hA1, 1'b0},  // R4 oe high
      {4'b0010, 8'hB2, 1'b1, 8'hB2, 1'b0},  // R2 data follows array
      {4'b0000, 8'hB2, 1'b0, 8'hB2, 1'b1},  // R5 late write
      {4'b0110, 8'hB2, 1'b0, 8'hB2, 1'b0},  // R3 column released
      {4'b0100, 8'hC3, 1'b0, 8'hB2, 1'b0},  // R6 we low first
      {4'b0000, 8'hC3, 1'b0, 8'hB2, 1'b1},  // R6 early write
      {4'b0010, 8'hC3, 1'b0, 8'hB2, 1'b0},  // R6 we back high, still floating
      {4'b0110, 8'hC3, 1'b0, 8'hB2, 1'b0},  // R3
      {4'b1110, 8'hC3, 1'b0, 8'hB2, 1'b0},  // R3 idle
      {4'b1010, 8'hD4, 1'b0, 8'hB2, 1'b0},  // R8 column-only
      {4'b1110, 8'hD4, 1'b0, 8'hB2, 1'b0},  // R8
      {4'b0110, 8'hE5, 1'b0, 8'hB2, 1'b0},  // R3
      {4'b0010, 8'hE5, 1'b1, 8'hE5, 1'b0},  // R2 read
      {4'b1010, 8'hE5, 1'b1, 8'hE5, 1'b0},  // R7 row rises, column low
      {4'b1010, 8'h66, 1'b1, 8'hE5, 1'b0},  // R7 latch ignores array
      {4'b1011, 8'h66, 1'b0, 8'hE5, 1'b0},  // R4 oe high keeps latch
      {4'b1010, 8'h66, 1'b1, 8'hE5, 1'b0},  // R4 restored
      {4'b0010, 8'h77, 1'b1, 8'hE5, 1'b0},  // R9 hidden refresh
      {4'b0011, 8'h77, 1'b0, 8'hE5, 1'b0},  // R9 oe gates
      {4'b0010, 8'h77, 1'b1, 8'hE5, 1'b0},  // R9
      {4'b1010, 8'h77, 1'b1, 8'hE5, 1'b0},  // R7 still held
      {4'b1110, 8'h77, 1'b0, 8'hE5, 1'b0},  // R7 column rises
      {4'b1000, 8'h88, 1'b0, 8'hE5, 1'b0},  // R8 column with we low
      {4'b0000, 8'h88, 1'b0, 8'hE5, 1'b0},  // R9 refresh, no write
      {4'b0010, 8'h88, 1'b0, 8'hE5, 1'b0},  // R9
      {4'b1110, 8'h88, 1'b0, 8'hE5, 1'b0}   // R9 end
   };
   localparam int REQ [NV] = '{3,2,4,2,5,3,6,6,6,3,3,8,8,3,2,7,7,4,4,9,9,9,7,7,8,9,9,9};

   task automatic chk(input int req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] s, input logic [DW-1:0] d);
      {ras_n, cas_n, we_n, oe_n} = s;
      rd_data = d;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(10, "reset dq_oe", dq_oe, 0);      // R10
      chk(10, "reset dq_out", dq_out, 0);    // R10
      chk(10, "reset arr_we", arr_we, 0);    // R10
      rst_n = 1'b1;
      repeat (4) @(posedge clk);

      for (int i = 0; i < NV; i++) begin
         int w0;
         @(posedge clk); #2;
         w0 = wcount;
         drive(VEC[i][21:18], VEC[i][17:10]);
         repeat (5) @(posedge clk);
         @(negedge clk);
         chk(REQ[i], $sformatf("step %0d dq_oe", i), dq_oe, VEC[i][9]);
         chk(REQ[i], $sformatf("step %0d dq_out", i), dq_out, VEC[i][8:1]);
         chk(REQ[i], $sformatf("step %0d pulses", i), wcount - w0, VEC[i][0]);
      end

      // R1: exact latency of a read turning the drivers on
      @(posedge clk); #2;
      drive(4'b0110, 8'h5C);
      repeat (5) @(posedge clk);
      #2;
      drive(4'b0010, 8'h5C);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(1, "dq_oe after two edges", dq_oe, 0);
      @(posedge clk);
      @(negedge clk);
      chk(1, "dq_oe after three edges", dq_oe, 1);
      chk(1, "dq_out after three edges", dq_out, 8'h5C);

      // R10: reset in the middle of a read
      #3 rst_n = 1'b0;
      #4;
      chk(10, "mid reset dq_oe", dq_oe, 0);
      chk(10, "mid reset dq_out", dq_out, 0);
      drive(4'b1111, 8'h00);
      repeat (2) @(posedge clk);
      #2 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(10, "after reset arr_we", arr_we, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule